// File: doc/BRIEF.md
# Multicycle Teaching Processor Core

A small multicycle processor for a teaching instruction set of 32-bit words. Every instruction word holds four 8-bit fields. From most significant to least significant they are the opcode, the first source register, the second source register and the destination register. The core reads each instruction through one synchronous single-port memory interface and then moves through decode and execute steps. Arithmetic and logic instructions use an eight-entry register file and an ALU that keeps a zero flag.

Memory-reference and control-transfer instructions use absolute addressing. Their address is the memory word that directly follows the instruction, and fetching that word advances the program counter once more. A return-address stack in hardware supports subroutine call and return.

Execution stops at HALT, at an undefined opcode, or when the return stack overflows or underflows. After that the core makes no further memory accesses until reset. `rst_n` is asynchronous and active low. It is expected to arrive already synchronised on its release edge.

Top module: `tcpu_core`

## Requirements
- R1: While reset is held and just after its release, `halted`, `illegal_op` and `stack_fault` are 0. The first access after release is a read (`mem_en`=1, `mem_we`=0) of byte address 0.
- R2: Each instruction is read at the program counter, and the counter then advances by 4. Memory read data is valid in the cycle after the request.
- R3: Instruction bits 31:24 are the opcode, 23:16 are source 1, 15:8 are source 2 and 7:0 are the destination. Only the low 3 bits of a register field select a register, and the upper bits are ignored.
- R4: The ALU opcodes are 0x00 ADD, 0x01 SUB (src1 − src2), 0x03 AND and 0x04 OR, each combining both sources. 0x05 NOT (bitwise inverse of src1) and 0x02 MOVE (copy of src1) use source 1 only. Each writes its result to the destination register.
- R5: Every ALU instruction sets the zero flag to 1 when its result is zero and to 0 otherwise. BZ (0x0A) is taken when the flag is 1 and BNZ (0x0B) when it is 0. A branch that is not taken continues at the word after its target word.
- R6: LOAD (0x06) reads the following word as an address, reads memory there and writes the value to the destination register.
- R7: STORE (0x07) reads the following word as an address and writes source register 1 there with `mem_en`=`mem_we`=1.
- R8: BR (0x08) always continues at the address held in the following word.
- R9: CALL (0x0C) pushes the address two words past itself and jumps to the following word's address. RET (0x0D) resumes at the most recently pushed address. Calls nest up to 8 deep.
- R10: HALT (0x09) raises `halted`, which then stays high, and no memory access follows.
- R11: An opcode outside the ones listed halts the core with `illegal_op`=1 and `stack_fault`=0.
- R12: A CALL with 8 entries already on the stack, or a RET with the stack empty, halts the core with `stack_fault`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_en | output | 1 | Memory access request this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Byte address (word aligned) |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid one cycle after a read request |
| halted | output | 1 | Core has stopped |
| illegal_op | output | 1 | Stopped on an undefined opcode |
| stack_fault | output | 1 | Stopped on return-stack overflow or underflow |

## Verification
Register contents cannot be seen at the ports, so every program stores each result it produces. A scoreboard then matches the stream of writes against the expected address and data. Any write nobody expected counts as a failure, so a wrongly taken or wrongly skipped branch shows up as a store to a trap address.

The hardest state to reach is a full return stack. A CALL whose target is itself fills all eight entries and then faults on the ninth call. Nested calls whose return path has its own store show that each return lands two words past its CALL.

// File: rtl/tcpu_pkg.sv
package tcpu_pkg;

  typedef enum logic [7:0] {
    OP_ADD   = 8'h00,
    OP_SUB   = 8'h01,
    OP_MOVE  = 8'h02,
    OP_AND   = 8'h03,
    OP_OR    = 8'h04,
    OP_NOT   = 8'h05,
    OP_LOAD  = 8'h06,
    OP_STORE = 8'h07,
    OP_BR    = 8'h08,
    OP_HALT  = 8'h09,
    OP_BZ    = 8'h0A,
    OP_BNZ   = 8'h0B,
    OP_CALL  = 8'h0C,
    OP_RET   = 8'h0D
  } opcode_e;

  typedef enum logic [2:0] {
    ST_FETCH,
    ST_DECODE,
    ST_EXEC,
    ST_OPND,
    ST_LOADWB,
    ST_HALT
  } state_e;

endpackage

// File: rtl/tcpu_alu.sv
module tcpu_alu
  import tcpu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  opcode_e         op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] res,
  output logic            zero
);

  always_comb begin
    case (op)
      OP_ADD:  res = a + b;
      OP_SUB:  res = a - b;
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_NOT:  res = ~a;
      default: res = a;
    endcase
  end

  assign zero = (res == '0);

endmodule

// File: rtl/tcpu_regfile.sv
module tcpu_regfile #(
  parameter int XLEN = 32,
  parameter int NREG = 8,
  localparam int AW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            we,
  input  logic [AW-1:0]   waddr,
  input  logic [XLEN-1:0] wdata,
  input  logic [AW-1:0]   raddr_a,
  input  logic [AW-1:0]   raddr_b,
  output logic [XLEN-1:0] rdata_a,
  output logic [XLEN-1:0] rdata_b
);

  logic [XLEN-1:0] regs [NREG];

  // One enable per entry; entries carry no reset.
  for (genvar g = 0; g < NREG; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (we && (waddr == AW'(g))) begin
        regs[g] <= wdata;
      end
    end
  end

  assign rdata_a = regs[raddr_a];
  assign rdata_b = regs[raddr_b];

endmodule

// File: rtl/tcpu_rstack.sv
module tcpu_rstack #(
  parameter int XLEN  = 32,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic            pop,
  input  logic [XLEN-1:0] push_data,
  output logic [XLEN-1:0] top_data,
  output logic            full,
  output logic            empty
);

  logic [XLEN-1:0] stk [DEPTH];
  logic [CW-1:0]   count_q, count_d;
  logic [AW-1:0]   wr_idx, rd_idx;

  assign wr_idx   = count_q[AW-1:0];
  assign rd_idx   = wr_idx - AW'(1);
  assign full     = (count_q == CW'(DEPTH));
  assign empty    = (count_q == '0);
  assign top_data = stk[rd_idx];

  always_comb begin
    count_d = count_q;
    if (push && !full) begin
      count_d = count_q + CW'(1);
    end else if (pop && !empty) begin
      count_d = count_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else begin
      count_q <= count_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !full) begin
      stk[wr_idx] <= push_data;
    end
  end

endmodule

// File: rtl/tcpu_core.sv
module tcpu_core
  import tcpu_pkg::*;
#(
  parameter int          XLEN        = 32,
  parameter int          NREG        = 8,
  parameter int          STACK_DEPTH = 8,
  parameter logic [31:0] RESET_PC    = 32'h0
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic            mem_en,
  output logic            mem_we,
  output logic [XLEN-1:0] mem_addr,
  output logic [XLEN-1:0] mem_wdata,
  input  logic [XLEN-1:0] mem_rdata,
  output logic            halted,
  output logic            illegal_op,
  output logic            stack_fault
);

  localparam int AW = $clog2(NREG);
  localparam logic [XLEN-1:0] WSTEP = XLEN'(4);

  state_e          state_q, state_d;
  logic [XLEN-1:0] pc_q, pc_d;
  logic [XLEN-1:0] ir_q;
  logic            zf_q, zf_d;
  logic            ill_q, ill_d;
  logic            flt_q, flt_d;

  opcode_e       opc;
  logic [AW-1:0] rs1, rs2, rd;
  logic          unused_fields;

  assign opc = opcode_e'(ir_q[31:24]);
  assign rs1 = ir_q[16 +: AW];
  assign rs2 = ir_q[8 +: AW];
  assign rd  = ir_q[0 +: AW];
  assign unused_fields = ^{ir_q[23:16+AW], ir_q[15:8+AW], ir_q[7:AW]};

  logic            rf_we;
  logic [XLEN-1:0] rf_wdata, rf_a, rf_b;
  logic [XLEN-1:0] alu_res;
  logic            alu_zero;
  logic            stk_push, stk_pop, stk_full, stk_empty;
  logic [XLEN-1:0] stk_top;

  tcpu_regfile #(.XLEN(XLEN), .NREG(NREG)) i_rf (
    .clk     (clk),
    .we      (rf_we),
    .waddr   (rd),
    .wdata   (rf_wdata),
    .raddr_a (rs1),
    .raddr_b (rs2),
    .rdata_a (rf_a),
    .rdata_b (rf_b)
  );

  tcpu_alu #(.XLEN(XLEN)) i_alu (
    .op   (opc),
    .a    (rf_a),
    .b    (rf_b),
    .res  (alu_res),
    .zero (alu_zero)
  );

  tcpu_rstack #(.XLEN(XLEN), .DEPTH(STACK_DEPTH)) i_rstk (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (stk_push),
    .pop       (stk_pop),
    .push_data (pc_q),
    .top_data  (stk_top),
    .full      (stk_full),
    .empty     (stk_empty)
  );

  // Next-state logic
  always_comb begin
    state_d   = state_q;
    pc_d      = pc_q;
    zf_d      = zf_q;
    ill_d     = ill_q;
    flt_d     = flt_q;
    mem_en    = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = pc_q;
    mem_wdata = rf_a;
    rf_we     = 1'b0;
    rf_wdata  = alu_res;
    stk_push  = 1'b0;
    stk_pop   = 1'b0;
    case (state_q)
      ST_FETCH: begin
        mem_en  = 1'b1;
        pc_d    = pc_q + WSTEP;
        state_d = ST_DECODE;
      end
      ST_DECODE: state_d = ST_EXEC;
      ST_EXEC: begin
        case (opc)
          OP_ADD, OP_SUB, OP_MOVE, OP_AND, OP_OR, OP_NOT: begin
            rf_we   = 1'b1;
            zf_d    = alu_zero;
            state_d = ST_FETCH;
          end
          OP_LOAD, OP_STORE, OP_BR, OP_BZ, OP_BNZ, OP_CALL: begin
            mem_en  = 1'b1;
            pc_d    = pc_q + WSTEP;
            state_d = ST_OPND;
          end
          OP_RET: begin
            if (stk_empty) begin
              flt_d   = 1'b1;
              state_d = ST_HALT;
            end else begin
              stk_pop = 1'b1;
              pc_d    = stk_top;
              state_d = ST_FETCH;
            end
          end
          OP_HALT: state_d = ST_HALT;
          default: begin
            ill_d   = 1'b1;
            state_d = ST_HALT;
          end
        endcase
      end
      ST_OPND: begin
        state_d  = ST_FETCH;
        mem_addr = mem_rdata;
        case (opc)
          OP_LOAD: begin
            mem_en  = 1'b1;
            state_d = ST_LOADWB;
          end
          OP_STORE: begin
            mem_en = 1'b1;
            mem_we = 1'b1;
          end
          OP_BR:  pc_d = mem_rdata;
          OP_BZ:  if (zf_q)  pc_d = mem_rdata;
          OP_BNZ: if (!zf_q) pc_d = mem_rdata;
          OP_CALL: begin
            if (stk_full) begin
              flt_d   = 1'b1;
              state_d = ST_HALT;
            end else begin
              stk_push = 1'b1;
              pc_d     = mem_rdata;
            end
          end
          default: state_d = ST_FETCH;
        endcase
      end
      ST_LOADWB: begin
        rf_we    = 1'b1;
        rf_wdata = mem_rdata;
        state_d  = ST_FETCH;
      end
      default: state_d = ST_HALT;
    endcase
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_FETCH;
      pc_q    <= RESET_PC;
      zf_q    <= 1'b0;
      ill_q   <= 1'b0;
      flt_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      pc_q    <= pc_d;
      zf_q    <= zf_d;
      ill_q   <= ill_d;
      flt_q   <= flt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (state_q == ST_DECODE) begin
      ir_q <= mem_rdata;
    end
  end

  assign halted      = (state_q == ST_HALT);
  assign illegal_op  = ill_q;
  assign stack_fault = flt_q;

endmodule

// File: rtl/tcpu_core_chk.sv
module tcpu_core_chk (
  input logic clk,
  input logic rst_n,
  input logic mem_en,
  input logic mem_we,
  input logic halted,
  input logic illegal_op,
  input logic stack_fault
);

  a_r10_quiet_when_halted: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !mem_en);

  a_r10_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);

  a_r7_write_is_access: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_en);

  a_r11_illegal_stops: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_op |-> halted);

  a_r12_fault_stops: assert property (@(posedge clk) disable iff (!rst_n)
    stack_fault |-> halted);

  a_r11_one_cause: assert property (@(posedge clk) disable iff (!rst_n)
    !(illegal_op && stack_fault));

endmodule

bind tcpu_core tcpu_core_chk i_tcpu_core_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mem_en      (mem_en),
  .mem_we      (mem_we),
  .halted      (halted),
  .illegal_op  (illegal_op),
  .stack_fault (stack_fault)
);

// File: tb/test_tcpu_core.sv
module test_tcpu_core;
  import tcpu_pkg::*;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mem_en, mem_we, halted, illegal_op, stack_fault;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tcpu_core i_tcpu_core (
    .clk(clk), .rst_n(rst_n), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .halted(halted), .illegal_op(illegal_op), .stack_fault(stack_fault)
  );

  // Program image, written only by the stimulus tasks
  logic [31:0] img [256];
  int wp;

  always @(posedge clk) begin
    if (mem_en && !mem_we) mem_rdata <= img[mem_addr[9:2]];
  end

  int n_chk = 0;
  int n_fail = 0;

  typedef struct {
    logic [31:0] a;
    logic [31:0] d;
    string       tag;
  } exp_t;
  exp_t        sb[$];
  logic [31:0] rd_log[$];
  int          halt_acc;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ins(input logic [7:0] op, input logic [7:0] s1,
                                      input logic [7:0] s2, input logic [7:0] d);
    return {op, s1, s2, d};
  endfunction

  task automatic clear_img();
    for (int i = 0; i < 256; i++) img[i] = ins(OP_HALT, 0, 0, 0);
    wp = 0;
  endtask
  task automatic org(input int a); wp = a / 4; endtask
  task automatic put(input logic [31:0] w); img[wp] = w; wp++; endtask
  task automatic expect_st(input logic [31:0] a, input logic [31:0] d, input string tag);
    exp_t e;
    e.a = a; e.d = d; e.tag = tag;
    sb.push_back(e);
  endtask

  // Monitor: scoreboard for writes, log of reads, accesses after halt
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_en && mem_we) begin
        if (sb.size() == 0) begin
          chk(1'b0, "unexpected store (R5/R7/R8)", mem_addr, 32'h0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          chk(mem_addr == e.a, {e.tag, " store address"}, mem_addr, e.a);
          chk(mem_wdata == e.d, {e.tag, " store data"}, mem_wdata, e.d);
        end
      end
      if (mem_en && !mem_we) rd_log.push_back(mem_addr);
      if (halted && mem_en) halt_acc++;
    end
  end

  task automatic run(input string name);
    bit done;
    rd_log.delete();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(!halted && !illegal_op && !stack_fault, {"R1 flags in reset ", name},
        {29'b0, halted, illegal_op, stack_fault}, 32'h0);
    rst_n = 1'b1;
    #1;
    chk(mem_en && !mem_we && mem_addr == 32'h0, {"R1 first fetch ", name}, mem_addr, 32'h0);
    done = 1'b0;
    for (int c = 0; c < 3000 && !done; c++) begin
      @(negedge clk);
      if (halted) done = 1'b1;
    end
    chk(done, {"R10 run reaches halt ", name}, {31'b0, done}, 32'h1);
    halt_acc = 0;
    repeat (20) @(negedge clk);
    chk(halt_acc == 0, {"R10 no access after halt ", name}, halt_acc, 0);
    chk(halted, {"R10 halted stays high ", name}, {31'b0, halted}, 32'h1);
    chk(sb.size() == 0, {"scoreboard drained ", name}, sb.size(), 0);
    sb.delete();
  endtask

  initial begin
    // Program A: loads, ALU ops, field decoding, stores
    clear_img();
    put(ins(OP_LOAD, 0, 0, 1)); put(32'h100);
    put(ins(OP_LOAD, 0, 0, 2)); put(32'h104);
    put(ins(OP_ADD, 1, 8'h3A, 3));              // R3: src2 field 0x3A selects r2
    put(ins(OP_STORE, 3, 0, 0)); put(32'h200);
    put(ins(OP_SUB, 1, 2, 4));
    put(ins(OP_STORE, 4, 0, 0)); put(32'h204);
    put(ins(OP_AND, 1, 2, 5));
    put(ins(OP_STORE, 5, 0, 0)); put(32'h208);
    put(ins(OP_OR, 1, 2, 6));
    put(ins(OP_STORE, 6, 0, 0)); put(32'h20C);
    put(ins(OP_NOT, 1, 0, 7));
    put(ins(OP_STORE, 7, 0, 0)); put(32'h210);
    put(ins(OP_MOVE, 8'h0A, 0, 8'hF8));         // R3: r0 <- r2
    put(ins(OP_STORE, 0, 0, 0)); put(32'h214);
    put(ins(OP_HALT, 0, 0, 0));
    img[64] = 32'd7; img[65] = 32'd5;
    expect_st(32'h200, 32'd12, "R4 ADD / R3 src2 field");
    expect_st(32'h204, 32'd2, "R4 SUB");
    expect_st(32'h208, 32'd5, "R4 AND");
    expect_st(32'h20C, 32'd7, "R4 OR");
    expect_st(32'h210, 32'hFFFF_FFF8, "R4 NOT");
    expect_st(32'h214, 32'd5, "R3 MOVE low-bit select / R7");
    run("A");
    chk(rd_log[1] == 32'h4, "R2 operand read after fetch", rd_log[1], 32'h4);
    chk(rd_log[2] == 32'h100, "R6 load address from following word", rd_log[2], 32'h100);
    chk(rd_log[3] == 32'h8, "R2 next fetch at PC+8", rd_log[3], 32'h8);
    chk(rd_log[6] == 32'h10, "R2 fetch after second load", rd_log[6], 32'h10);
    chk(!illegal_op && !stack_fault, "R10 clean halt flags A", {30'b0, illegal_op, stack_fault}, 0);

    // Program B: zero flag and branches (R5, R8); trap stores go to 0x2F0
    clear_img();
    put(ins(OP_LOAD, 0, 0, 1)); put(32'h100);
    put(ins(OP_LOAD, 0, 0, 2)); put(32'h104);
    put(ins(OP_SUB, 1, 2, 3));
    put(ins(OP_BZ, 0, 0, 0)); put(32'h80);
    put(ins(OP_STORE, 1, 0, 0)); put(32'h2F0);
    put(ins(OP_HALT, 0, 0, 0));
    org(32'h80);
    put(ins(OP_BNZ, 0, 0, 0)); put(32'hE0);
    put(ins(OP_STORE, 3, 0, 0)); put(32'h200);
    put(ins(OP_ADD, 1, 2, 4));
    put(ins(OP_BZ, 0, 0, 0)); put(32'hE0);
    put(ins(OP_STORE, 4, 0, 0)); put(32'h204);
    put(ins(OP_BNZ, 0, 0, 0)); put(32'hC0);
    put(ins(OP_STORE, 1, 0, 0)); put(32'h2F0);
    put(ins(OP_HALT, 0, 0, 0));
    org(32'hC0);
    put(ins(OP_BR, 0, 0, 0)); put(32'hD0);
    put(ins(OP_STORE, 1, 0, 0)); put(32'h2F0);
    put(ins(OP_STORE, 1, 0, 0)); put(32'h208);
    put(ins(OP_HALT, 0, 0, 0));
    org(32'hE0);
    put(ins(OP_STORE, 1, 0, 0)); put(32'h2F0);
    put(ins(OP_HALT, 0, 0, 0));
    img[64] = 32'd3; img[65] = 32'd3;
    expect_st(32'h200, 32'd0, "R5 BZ taken, BNZ not taken on zero");
    expect_st(32'h204, 32'd6, "R5 BZ not taken on nonzero");
    expect_st(32'h208, 32'd3, "R5 BNZ taken / R8 BR");
    run("B");

    // Program C: nested call and return (R9)
    clear_img();
    put(ins(OP_LOAD, 0, 0, 1)); put(32'h100);
    put(ins(OP_CALL, 0, 0, 0)); put(32'h40);
    put(ins(OP_STORE, 2, 0, 0)); put(32'h200);
    put(ins(OP_HALT, 0, 0, 0));
    org(32'h40);
    put(ins(OP_MOVE, 1, 0, 2));
    put(ins(OP_CALL, 0, 0, 0)); put(32'h60);
    put(ins(OP_STORE, 2, 0, 0)); put(32'h204);
    put(ins(OP_RET, 0, 0, 0));
    org(32'h60);
    put(ins(OP_ADD, 2, 2, 2));
    put(ins(OP_RET, 0, 0, 0));
    img[64] = 32'd10;
    expect_st(32'h204, 32'd20, "R9 inner return");
    expect_st(32'h200, 32'd20, "R9 outer return");
    run("C");
    chk(!stack_fault, "R9 balanced calls no fault", {31'b0, stack_fault}, 0);

    // Program D: undefined opcode (R11)
    clear_img();
    put(ins(8'h0E, 0, 0, 0));
    run("D");
    chk(illegal_op && !stack_fault, "R11 illegal flag", {30'b0, illegal_op, stack_fault}, 32'h2);
    chk(rd_log.size() == 1, "R11 only the fetch happened", rd_log.size(), 1);

    // Program E: return on empty stack (R12)
    clear_img();
    put(ins(OP_RET, 0, 0, 0));
    run("E");
    chk(stack_fault && !illegal_op, "R12 underflow fault", {30'b0, illegal_op, stack_fault}, 32'h1);

    // Program F: self-call fills the stack, ninth call faults (R12)
    clear_img();
    put(ins(OP_CALL, 0, 0, 0)); put(32'h0);
    run("F");
    chk(stack_fault && !illegal_op, "R12 overflow fault", {30'b0, illegal_op, stack_fault}, 32'h1);
    chk(rd_log.size() == 18, "R12 nine calls fetched", rd_log.size(), 18);

    // Program G: bare HALT (R10)
    clear_img();
    put(ins(OP_HALT, 0, 0, 0));
    run("G");
    chk(!illegal_op && !stack_fault, "R10 HALT raises no error", {30'b0, illegal_op, stack_fault}, 0);
    chk(rd_log.size() == 1, "R10 single fetch before halt", rd_log.size(), 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule